// File: doc/BRIEF.md
# Serial Register Access Bridge

This block is a serial-peripheral slave (clock idle low, data sampled on the rising clock edge, changed on the falling edge, 8-bit bytes) that gives an external host read and write access to a 32-bit word-addressed register space. Every frame opens with three address bytes. The top bit of the first byte selects write or read, and the remaining 23 bits are a word index. The address is followed by exactly 32 payload bits. A write frame hands its payload to the internal register port as a single-cycle request. A read frame issues the request as soon as the last address bit arrives. The host then clocks a programmable number of filler bytes, which gives a slow register time to answer before the first payload bit must appear on the output.

Two registers live inside the bridge at a fixed pair of word indices. The format register chooses the payload byte order and the bit order within each byte. The setup register holds the filler-byte count, a sticky flag that records a read whose data was not ready in time, and a constant interface code. The address is always sent big-endian, most significant bit first, whatever the format register says. Reset returns both registers to their defaults, so the host programs them again before it does anything else.

Top module: `spi_reg_bridge`

## Requirements
- R1: A frame's first 24 bits, most significant first, are the address field. The first bit is 1 for a write and 0 for a read. The other 23 bits form the word index, which the bridge drives on `reg_addr` when it issues a request.
- R2: In a write frame to a non-local index, one cycle of `reg_req` with `reg_we`=1 follows the 56th rising clock edge. It carries the word index and the payload decoded with the active format.
- R3: In a read frame to a non-local index, one cycle of `reg_req` with `reg_we`=0 follows the 24th rising edge. After P filler bytes, where P is setup bits 3:0, the value returned with `reg_ack` is shifted out. With P=0 the payload follows the address at once. `miso` is 0 during the address and the filler bytes and while chip select is high.
- R4: Word index 0x400000 is the format register and 0x400001 is the setup register. Accesses to either never raise `reg_req`. The setup register reads back with P in bits 3:0, the late-data flag in bit 16, the value 2 in bits 31:24, and 0 everywhere else.
- R5: If `reg_ack` has not arrived when the falling edge that places the first read payload bit is reached, the bridge sets the late-data flag and shifts out 32 zero bits. The flag stays set.
- R6: Format bit 0 set means big-endian: the first payload byte carries bits 31:24. Clear means little-endian: the first byte carries bits 7:0. Format bit 1 set means each byte travels least significant bit first. The format applies to both write and read payloads.
- R7: A write to the format register loads bits 1:0 of the word after it has been decoded with the current format. Reading the format register returns every byte as {f0,f1,0000,f1,f0}. The byte values 0x00, 0x81, 0x42 and 0xC3, repeated four times, therefore select formats 00, 01, 10 and 11 from any starting format.
- R8: After reset, the format is 00, P is 0, the flag is clear, and `miso` and `reg_req` are 0.
- R9: If chip select rises before the 32nd payload bit of a write, nothing is committed. There is no `reg_req`, and the local registers keep their values.
- R10: A write to the setup register loads P from bits 3:0 and clears the late-data flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select from the host, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| reg_req | output | 1 | Single-cycle register access request |
| reg_we | output | 1 | 1 for a write request, 0 for a read request |
| reg_addr | output | 23 | Word index of the access |
| reg_wdata | output | 32 | Write data, decoded |
| reg_ack | input | 1 | Read data valid |
| reg_rdata | input | 32 | Read data |

## Verification
The bench sets the register latency on both sides of the data deadline, with zero and with two filler bytes. A bridge that tested readiness at the wrong falling edge would either return stale data without raising the flag or raise the flag on a read that arrived in time. All four payload formats are run through writes and reads, and format changes are made from a non-default format. A swapped byte or bit order shows up as a wrong `reg_wdata` or a wrong received word. Frames cut short check that a partial write never reaches the port or a local register. A reset in the middle of the run checks that both local registers go back to their defaults.

// File: rtl/spi_reg_bridge_pkg.sv
// Shared constants and payload helpers for the serial register bridge.
// Assumes a 32-bit payload, and a wire word whose bit 31 is the first bit on the line.
package spi_reg_bridge_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int FMT_W       = 2;
    localparam int FMT_BIG_BIT = 0;   // 1: first payload byte is the high byte
    localparam int FMT_LSB_BIT = 1;   // 1: least significant bit of each byte goes first

    // Converts between the wire order and the register value. The mapping is its own inverse.
    function automatic logic [WORD_W-1:0] fmt_swap(input logic [WORD_W-1:0] w,
                                                   input logic [FMT_W-1:0]  fmt);
        logic [WORD_W-1:0] t;
        logic [WORD_W-1:0] r;
        t = w;
        if (fmt[FMT_LSB_BIT]) begin
            for (int k = 0; k < WORD_W; k++)
                t[k] = w[(k / BYTE_W) * BYTE_W + (BYTE_W - 1 - (k % BYTE_W))];
        end
        r = t;
        if (!fmt[FMT_BIG_BIT]) begin
            for (int b = 0; b < WORD_W / BYTE_W; b++)
                r[b*BYTE_W +: BYTE_W] = t[(WORD_W/BYTE_W - 1 - b)*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Brings the host pins into the clk domain and detects serial clock edges.
// Assumes clk runs at least eight times faster than sclk. mosi passes through the same
// number of stages as sclk, so the value seen at a detected rise is the one the host set up.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES:0]   sclk_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;

    // Shift the pins through the synchronizer stages; sclk gets one more stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[STAGES-1:0], sclk};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
        end
    end

    assign cs_act    = ~cs_p[STAGES-1];
    assign mosi_s    = mosi_p[STAGES-1];
    assign sclk_rise = cs_act &  sclk_p[STAGES-1] & ~sclk_p[STAGES];
    assign sclk_fall = cs_act & ~sclk_p[STAGES-1] &  sclk_p[STAGES];

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_fall);
endmodule

// File: rtl/spi_cfg_regs.sv
// Holds the payload format register and the setup/status register.
// Assumes at most one write strobe per cycle. A setup write takes priority over a
// late-data event in the same cycle.
module spi_cfg_regs #(
    parameter int          PAD_W = 4,
    parameter logic [7:0]  IF_ID = 8'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_we,
    input  logic [1:0]       fmt_d,
    input  logic             setup_we,
    input  logic [PAD_W-1:0] pad_d,
    input  logic             late_set,
    output logic [1:0]       fmt,
    output logic [PAD_W-1:0] pad,
    output logic [31:0]      fmt_word,
    output logic [31:0]      setup_word
);
    localparam int LATE_BIT = 16;
    localparam int ID_LSB   = 24;

    logic late_q;

    // Format register: loaded only by a committed local write.
    always_ff @(posedge clk) begin
        if (!rst_n)      fmt <= 2'b00;
        else if (fmt_we) fmt <= fmt_d;
    end

    // Filler count and sticky late-data flag; a setup write reloads one and clears the other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad    <= '0;
            late_q <= 1'b0;
        end else if (setup_we) begin
            pad    <= pad_d;
            late_q <= 1'b0;
        end else if (late_set) begin
            late_q <= 1'b1;
        end
    end

    // Format readback repeats a bit-order-symmetric byte so it reads the same in every format.
    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_fmt_byte
            assign fmt_word[g*8 +: 8] = {fmt[0], fmt[1], 4'b0000, fmt[1], fmt[0]};
        end
    endgenerate

    // Setup readback assembly.
    always_comb begin
        setup_word                    = '0;
        setup_word[PAD_W-1:0]         = pad;
        setup_word[LATE_BIT]          = late_q;
        setup_word[ID_LSB +: 8]       = IF_ID;
    end

    // R5
    late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_set && !setup_we) |=> setup_word[LATE_BIT]);
    // R10
    late_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_we |=> !setup_word[LATE_BIT]);
    // R7
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_we |=> $stable(fmt));
endmodule

// File: rtl/spi_frame_ctl.sv
// Parses a frame: address field, optional filler bytes and a 32-bit payload.
// It issues the register request, captures read data, drives miso and flags late data.
// Assumes the edge pulses come from spi_pin_sync, and that a read completes before the
// next read request of a following frame is issued.
module spi_frame_ctl
    import spi_reg_bridge_pkg::*;
#(
    parameter int                    ADDR_BITS  = 24,
    parameter int                    PAD_W      = 4,
    parameter logic [ADDR_BITS-2:0]  LOCAL_WORD = 23'h400000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  cs_act,
    input  logic                  mosi_s,
    input  logic [FMT_W-1:0]      fmt,
    input  logic [PAD_W-1:0]      pad,
    input  logic [WORD_W-1:0]     fmt_word,
    input  logic [WORD_W-1:0]     setup_word,
    input  logic                  reg_ack,
    input  logic [WORD_W-1:0]     reg_rdata,
    output logic                  miso,
    output logic                  reg_req,
    output logic                  reg_we,
    output logic [ADDR_BITS-2:0]  reg_addr,
    output logic [WORD_W-1:0]     reg_wdata,
    output logic                  fmt_we,
    output logic [FMT_W-1:0]      fmt_d,
    output logic                  setup_we,
    output logic [PAD_W-1:0]      pad_d,
    output logic                  late_set
);
    localparam int WADDR_W   = ADDR_BITS - 1;
    localparam int CNT_LIMIT = ADDR_BITS + BYTE_W * ((1 << PAD_W) - 1) + WORD_W + 1;
    localparam int CNT_W     = $clog2(CNT_LIMIT + 1);
    localparam logic [CNT_W-1:0] C_ADDR   = CNT_W'(ADDR_BITS);
    localparam logic [CNT_W-1:0] C_ADDR_L = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] C_WR_L   = CNT_W'(ADDR_BITS + WORD_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic               is_wr;
    logic [WADDR_W-1:0] addr_q;
    logic [WORD_W-2:0]  data_sr;
    logic [PAD_W-1:0]   pad_q;
    logic               pend;
    logic               rd_valid;
    logic [WORD_W-1:0]  rd_buf;
    logic [WORD_W-1:0]  tx_sr;

    logic [WADDR_W-1:0] next_addr;
    logic [WORD_W-1:0]  wr_word;
    logic [CNT_W-1:0]   data_start;
    logic               addr_last;
    logic               wr_last;
    logic               ld_fall;
    logic               sh_fall;
    logic               next_local;
    logic               cur_local;

    assign next_addr  = {addr_q[WADDR_W-2:0], mosi_s};
    assign wr_word    = fmt_swap({data_sr, mosi_s}, fmt);
    assign data_start = C_ADDR + CNT_W'({pad_q, 3'b000});
    assign addr_last  = sclk_rise && (cnt == C_ADDR_L);
    assign wr_last    = sclk_rise && is_wr && (cnt == C_WR_L);
    assign ld_fall    = sclk_fall && !is_wr && (cnt == data_start);
    assign sh_fall    = sclk_fall && !is_wr && (cnt > data_start);
    assign next_local = (next_addr[WADDR_W-1:1] == LOCAL_WORD[WADDR_W-1:1]);
    assign cur_local  = (addr_q[WADDR_W-1:1]    == LOCAL_WORD[WADDR_W-1:1]);

    // Count rising edges within the frame; chip select release restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)               cnt <= '0;
        else if (sclk_rise && (cnt != '1))   cnt <= cnt + 1'b1;
    end

    // Capture the direction flag and the word index from the address field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr  <= 1'b0;
            addr_q <= '0;
        end else if (sclk_rise) begin
            if (cnt == '0)          is_wr  <= mosi_s;
            else if (cnt < C_ADDR)  addr_q <= next_addr;
        end
    end

    // Shift in payload bits after the address field.
    always_ff @(posedge clk) begin
        if (!rst_n)                            data_sr <= '0;
        else if (sclk_rise && cnt >= C_ADDR)   data_sr <= {data_sr[WORD_W-3:0], mosi_s};
    end

    // Snapshot the filler count when the address completes, so the frame uses one value.
    always_ff @(posedge clk) begin
        if (!rst_n)         pad_q <= '0;
        else if (addr_last) pad_q <= pad;
    end

    // Issue register requests and local write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_req   <= 1'b0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            fmt_we    <= 1'b0;
            setup_we  <= 1'b0;
            fmt_d     <= '0;
            pad_d     <= '0;
        end else begin
            reg_req  <= 1'b0;
            fmt_we   <= 1'b0;
            setup_we <= 1'b0;
            if (addr_last && !is_wr && !next_local) begin
                reg_req  <= 1'b1;
                reg_we   <= 1'b0;
                reg_addr <= next_addr;
            end
            if (wr_last) begin
                if (cur_local) begin
                    fmt_we   <= ~addr_q[0];
                    setup_we <=  addr_q[0];
                    fmt_d    <= wr_word[FMT_W-1:0];
                    pad_d    <= wr_word[PAD_W-1:0];
                end else begin
                    reg_req   <= 1'b1;
                    reg_we    <= 1'b1;
                    reg_addr  <= addr_q;
                    reg_wdata <= wr_word;
                end
            end
        end
    end

    // Track the outstanding read and hold its result, or the local register value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            rd_valid <= 1'b0;
            rd_buf   <= '0;
        end else if (addr_last && !is_wr) begin
            if (next_local) begin
                pend     <= 1'b0;
                rd_valid <= 1'b1;
                rd_buf   <= next_addr[0] ? setup_word : fmt_word;
            end else begin
                pend     <= 1'b1;
                rd_valid <= 1'b0;
            end
        end else if (pend && reg_ack) begin
            pend     <= 1'b0;
            rd_valid <= 1'b1;
            rd_buf   <= reg_rdata;
        end
    end

    // Load the payload at the deadline edge, then shift one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            tx_sr    <= '0;
            late_set <= 1'b0;
        end else begin
            late_set <= 1'b0;
            if (ld_fall) begin
                if (rd_valid) begin
                    tx_sr <= fmt_swap(rd_buf, fmt);
                end else begin
                    tx_sr    <= '0;
                    late_set <= 1'b1;
                end
            end else if (sh_fall) begin
                tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sr[WORD_W-1];

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> !reg_req);
    // R3
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso);
    // R9
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !reg_req);
endmodule

// File: rtl/spi_reg_bridge.sv
// Top of the serial register access bridge: pin synchronizer, frame controller and
// the two local configuration registers.
// Assumes clk is at least eight times faster than sclk, and that the register port returns
// reg_ack exactly once for each read request.
module spi_reg_bridge #(
    parameter int                    ADDR_BITS  = 24,
    parameter int                    PAD_W      = 4,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [ADDR_BITS-2:0]  LOCAL_WORD = 23'h400000,
    parameter logic [7:0]            IF_ID      = 8'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 mosi,
    output logic                 miso,
    output logic                 reg_req,
    output logic                 reg_we,
    output logic [ADDR_BITS-2:0] reg_addr,
    output logic [31:0]          reg_wdata,
    input  logic                 reg_ack,
    input  logic [31:0]          reg_rdata
);
    logic             sclk_rise, sclk_fall, cs_act, mosi_s;
    logic [1:0]       fmt, fmt_d;
    logic [PAD_W-1:0] pad, pad_d;
    logic [31:0]      fmt_word, setup_word;
    logic             fmt_we, setup_we, late_set;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_frame_ctl #(.ADDR_BITS(ADDR_BITS), .PAD_W(PAD_W), .LOCAL_WORD(LOCAL_WORD)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s),
        .fmt(fmt), .pad(pad), .fmt_word(fmt_word), .setup_word(setup_word),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .miso(miso), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata),
        .fmt_we(fmt_we), .fmt_d(fmt_d), .setup_we(setup_we), .pad_d(pad_d),
        .late_set(late_set)
    );

    spi_cfg_regs #(.PAD_W(PAD_W), .IF_ID(IF_ID)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .fmt_we(fmt_we), .fmt_d(fmt_d), .setup_we(setup_we), .pad_d(pad_d),
        .late_set(late_set),
        .fmt(fmt), .pad(pad), .fmt_word(fmt_word), .setup_word(setup_word)
    );
endmodule

// File: tb/spi_reg_bridge_test.sv
`timescale 1ns/1ps
module spi_reg_bridge_test;
    localparam int HALF = 6;
    localparam logic [22:0] A_FMT   = 23'h400000;
    localparam logic [22:0] A_SETUP = 23'h400001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, reg_req, reg_we, reg_ack;
    logic [22:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int vectors = 0, fails = 0, req_cnt = 0, lat = 2;
    bit done = 1'b0;
    logic        last_we;
    logic [22:0] last_addr;
    logic [31:0] last_wdata;
    logic [31:0] rd_value = 32'h0;

    always #2.5 clk = ~clk;

    spi_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    // Register port model: log each request, answer reads after lat cycles.
    initial begin
        reg_ack = 1'b0; reg_rdata = '0;
        forever begin
            @(negedge clk);
            if (reg_req === 1'b1) begin
                req_cnt++;
                last_we = reg_we; last_addr = reg_addr; last_wdata = reg_wdata;
                if (!reg_we) begin
                    repeat (lat - 1) @(negedge clk);
                    reg_ack = 1'b1; reg_rdata = rd_value;
                    @(negedge clk);
                    reg_ack = 1'b0;
                end
            end
        end
    end

    function automatic logic [31:0] to_wire(logic [31:0] v, logic [1:0] f);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] b;
            b = f[0] ? v[31-8*k -: 8] : v[8*k +: 8];
            if (f[1]) for (int j = 0; j < 8; j++) w[31-8*k-j] = b[j];
            else w[31-8*k -: 8] = b;
        end
        return w;
    endfunction

    function automatic logic [31:0] fmt_pat(logic [1:0] f);
        return {4{f[0], f[1], 4'b0000, f[1], f[0]}};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic frame(input logic wr, input logic [22:0] a, input logic [31:0] wout,
                         input int pads, input int dbits,
                         output logic [31:0] win, output bit quiet);
        logic r;
        quiet = 1'b1; win = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            xfer_bit((i == 0) ? wr : a[23-i], r);
            if (r !== 1'b0) quiet = 1'b0;
        end
        for (int i = 0; i < pads * 8; i++) begin
            xfer_bit(1'b0, r);
            if (r !== 1'b0) quiet = 1'b0;
        end
        for (int i = 0; i < dbits; i++) begin
            xfer_bit(wout[31-i], r);
            win[31-i] = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic rd(input logic [22:0] a, input int pads, input logic [1:0] f,
                      output logic [31:0] v, output bit quiet);
        logic [31:0] w;
        frame(1'b0, a, 32'h0, pads, 32, w, quiet);
        v = to_wire(w, f);
    endtask

    task automatic wr(input logic [22:0] a, input logic [31:0] v, input logic [1:0] f);
        logic [31:0] w; bit q;
        frame(1'b1, a, to_wire(v, f), 0, 32, w, q);
    endtask

    task automatic t_reset;
        logic [31:0] v; bit q;
        check("R8 miso after reset", {31'b0, miso}, 32'h0);
        check("R8 reg_req after reset", {31'b0, reg_req}, 32'h0);
        rd(A_SETUP, 0, 2'b00, v, q);
        check("R4 R8 setup default", v, 32'h0200_0000);
        rd(A_FMT, 0, 2'b00, v, q);
        check("R8 format default", v, 32'h0);
        check("R4 local no request", req_cnt, 0);
    endtask

    task automatic t_write(input logic [1:0] f, input logic [31:0] v, input logic [22:0] a);
        int c0;
        c0 = req_cnt;
        wr(a, v, f);
        check("R2 one request", req_cnt - c0, 1);
        check("R2 write enable", {31'b0, last_we}, 32'h1);
        check("R1 word index", {9'b0, last_addr}, {9'b0, a});
        check($sformatf("R6 write payload fmt %0d", f), last_wdata, v);
    endtask

    task automatic t_read(input logic [1:0] f, input int pads, input int l,
                          input logic [31:0] v, input logic [22:0] a);
        logic [31:0] got; bit q;
        lat = l; rd_value = v;
        rd(a, pads, f, got, q);
        check("R3 read request kind", {31'b0, last_we}, 32'h0);
        check("R1 read word index", {9'b0, last_addr}, {9'b0, a});
        check($sformatf("R3 R6 read data fmt %0d pad %0d", f, pads), got, v);
        check("R3 miso quiet before data", {31'b0, q}, 32'h1);
    endtask

    task automatic t_late;
        logic [31:0] got; bit q;
        lat = 20; rd_value = 32'hDEAD_BEEF;
        rd(23'h000123, 0, 2'b00, got, q);
        check("R5 late data zero", got, 32'h0);
        lat = 2;
        rd(A_SETUP, 0, 2'b00, got, q);
        check("R5 late flag set", got, 32'h0201_0000);
        rd(A_SETUP, 0, 2'b00, got, q);
        check("R5 late flag sticky", got, 32'h0201_0000);
    endtask

    task automatic t_setup;
        logic [31:0] got; bit q;
        wr(A_SETUP, 32'h0000_0002, 2'b00);
        rd(A_SETUP, 2, 2'b00, got, q);
        check("R10 pad loaded flag cleared", got, 32'h0200_0002);
        t_read(2'b00, 2, 20, 32'hCAFE_F00D, 23'h00ABCD);
        rd(A_SETUP, 2, 2'b00, got, q);
        check("R5 no flag when in time", got, 32'h0200_0002);
        wr(A_SETUP, 32'h0, 2'b00);
    endtask

    task automatic t_formats;
        logic [31:0] got; bit q;
        logic [1:0] cur;
        cur = 2'b00;
        for (int n = 0; n < 4; n++) begin
            logic [1:0] nf;
            nf = (n == 3) ? 2'b00 : 2'(3 - n);
            frame(1'b1, A_FMT, fmt_pat(nf), 0, 32, got, q);
            cur = nf;
            rd(A_FMT, 0, cur, got, q);
            check($sformatf("R7 format readback %0d", nf), got, fmt_pat(nf));
            t_write(cur, 32'h1122_3344 + 32'(n), 23'h012345);
            t_read(cur, 0, 2, 32'h8765_4321 ^ 32'(n), 23'h7F0001);
        end
    endtask

    task automatic t_abort;
        logic [31:0] got; bit q;
        int c0;
        c0 = req_cnt;
        frame(1'b1, 23'h000042, 32'h5555_AAAA, 0, 31, got, q);
        check("R9 partial remote write dropped", req_cnt - c0, 0);
        frame(1'b1, A_SETUP, to_wire(32'h5, 2'b00), 0, 20, got, q);
        rd(A_SETUP, 0, 2'b00, got, q);
        check("R9 partial setup write dropped", got, 32'h0200_0000);
        check("R4 local accesses no request", req_cnt - c0, 0);
    endtask

    task automatic t_midreset;
        logic [31:0] got; bit q;
        wr(A_SETUP, 32'h3, 2'b00);
        wr(A_FMT, 32'hC3C3_C3C3, 2'b00);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_SETUP, 0, 2'b00, got, q);
        check("R8 setup after reset", got, 32'h0200_0000);
        rd(A_FMT, 0, 2'b00, got, q);
        check("R8 format after reset", got, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(2'b00, 32'h1122_3344, 23'h000010);
        t_read(2'b00, 0, 2, 32'hA1B2_C3D4, 23'h000020);
        t_late();
        t_setup();
        t_formats();
        t_abort();
        t_midreset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule